// File: doc/BRIEF.md
# SPI Flash Status Register Controller

This block is the status and write-protection core of a serial flash device. It sits behind an SPI slave port and keeps a one-byte status word. The word holds a busy flag, a write-arm latch, three guard bits that fence off the top of the sector space, and a lock bit. When the lock bit is set and the protect pin is held low, the lock bit and the guard bits cannot be changed. The host reads the status word at any time, and the word repeats for as long as chip select stays low. The host arms and disarms writes. The block then decides whether a status write, page program, sector erase or bulk erase may start.

When a job is accepted, the block issues a one-clock start pulse to the program/erase engine, together with the job kind and the target address, and sets the busy flag. The engine ends the job with a done pulse, which clears both busy and the write-arm latch. All SPI pins are oversampled by the system clock through synchronizers, so the block works in SPI mode 0 and in mode 3. Serial data is taken on the rising edge of the serial clock and driven out after the falling edge.

Top module: `spi_stat_ctrl`

## Requirements
- R1: The status byte reads, from bit 7 down to bit 0, {lock, 0, 0, guard[2:0], armed, busy}. After reset it is 0x00 and `job_start` is 0.
- R2: After opcode 0x05 the status byte is shifted out MSB first on `spi_miso`, beginning with the falling serial-clock edge after the eighth clock. `spi_miso_oe` stays 0 during the opcode byte. While chip select stays low, the byte repeats, and each repeat takes a fresh copy of the status.
- R3: Opcode 0x06 sets `armed` and opcode 0x04 clears it. Each takes effect only for a frame of exactly one byte.
- R4: Opcodes 0x01 (status write), 0x02 (page program), 0xD8 (sector erase) and 0xC7 (bulk erase) are refused while `armed` is 0. A refused command leaves the status unchanged and gives no `job_start`.
- R5: An accepted status write is a 2-byte frame. It copies data bit 7 into `lock` and data bits 4:2 into `guard`, sets `busy`, and pulses `job_start` with kind 0. A `job_done` pulse while busy clears both `busy` and `armed`.
- R6: While `lock` is 1 and `prot_n` is 0, a status write is refused.
- R7: Bulk erase is a 1-byte frame. It is accepted (kind 3) only when `guard` is 0.
- R8: Page program (at least 4 bytes, kind 1) and sector erase (exactly 4 bytes, kind 2) take a 24-bit big-endian address after the opcode, and `job_addr` takes its low `ADDR_W` bits. The sector is the top 4 bits of that address. With guard value g from 1 to 4, the top 2^(g-1) sectors of 16 are refused. With g from 5 to 7, all sectors are refused.
- R9: While `busy` is 1, every opcode except 0x05 is ignored, including 0x06 and 0x04.
- R10: A command runs only if chip select rises on a byte boundary. A frame that ends part-way through a byte does nothing.
- R11: `job_start` lasts exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the SPI pins |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock (mode 0 or 3) |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data in |
| prot_n | input | 1 | Write-protect pin, active low |
| job_done | input | 1 | One-clock pulse when the program/erase engine finishes |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Output enable for `spi_miso` (0 = high impedance) |
| job_start | output | 1 | One-clock pulse when a job is accepted |
| job_kind | output | 2 | 0 status write, 1 page program, 2 sector erase, 3 bulk erase |
| job_addr | output | ADDR_W | Target address for program and erase |

## Verification
The hardest case to reach is a status read that overlaps the end of a job: the busy flag must change between two repeats of the status byte inside one chip-select frame. The bench arranges this by pulsing `job_done` between the last rising clock of the first repeated byte and the falling clock that starts the second. It then expects the first copy to show busy and the second copy to show idle and disarmed. Other cases are reached from the ports in the same way: protection edges are driven by setting the guard value through real status writes and then aiming erases at sectors just inside and just outside the fenced range, and partial-byte frames are made by stopping the clock three bits into a byte.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;

  localparam logic [7:0] OPC_RD_STAT  = 8'h05;
  localparam logic [7:0] OPC_WR_STAT  = 8'h01;
  localparam logic [7:0] OPC_WR_EN    = 8'h06;
  localparam logic [7:0] OPC_WR_DIS   = 8'h04;
  localparam logic [7:0] OPC_PROG     = 8'h02;
  localparam logic [7:0] OPC_SECT_ERS = 8'hD8;
  localparam logic [7:0] OPC_BULK_ERS = 8'hC7;

  typedef enum logic [1:0] {
    JOB_WRSTAT = 2'd0,
    JOB_PROG   = 2'd1,
    JOB_SECT   = 2'd2,
    JOB_BULK   = 2'd3
  } job_e;

endpackage

// File: rtl/spi_stat_sync.sv
module spi_stat_sync #(
  parameter int              WIDTH   = 4,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [WIDTH-1:0] r;
    logic [WIDTH-1:0] src;
    if (g == 0) begin : g_in
      assign src = d;
    end else begin : g_chain
      assign src = g_stage[g-1].r;
    end
    always_ff @(posedge clk) begin
      if (rst) r <= RST_VAL;
      else     r <= src;
    end
  end

  assign q = g_stage[STAGES-1].r;

endmodule

// File: rtl/spi_stat_frontend.sv
module spi_stat_frontend
  import spi_stat_pkg::*;
#(
  parameter int ARG_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sck,
  input  logic             cs_n,
  input  logic             mosi,
  input  logic [7:0]       stat_byte,
  output logic             miso,
  output logic             miso_oe,
  output logic             cmd_valid,
  output logic [7:0]       opcode,
  output logic [2:0]       frame_n,
  output logic [ARG_W-1:0] arg
);

  localparam logic [2:0] MAX_BYTES = 3'd5;
  localparam logic [2:0] ARG_BYTES = 3'(ARG_W / 8);

  logic       sck_q, cs_q;
  logic [2:0] bit_cnt, byte_cnt, obit;
  logic [6:0] in_sh;
  logic [7:0] out_sh;
  logic [7:0] rx_byte;
  logic       rise, fall;

  assign rx_byte = {in_sh, mosi};
  assign rise    = sck & ~sck_q & ~cs_n;
  assign fall    = ~sck & sck_q & ~cs_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q     <= 1'b0;
      cs_q      <= 1'b1;
      bit_cnt   <= '0;
      byte_cnt  <= '0;
      obit      <= '0;
      in_sh     <= '0;
      out_sh    <= '0;
      miso      <= 1'b0;
      miso_oe   <= 1'b0;
      cmd_valid <= 1'b0;
      opcode    <= '0;
      frame_n   <= '0;
      arg       <= '0;
    end else begin
      sck_q     <= sck;
      cs_q      <= cs_n;
      cmd_valid <= 1'b0;
      if (cs_n) begin
        if (!cs_q) begin
          cmd_valid <= (bit_cnt == 3'd0) && (byte_cnt != 3'd0);
          frame_n   <= byte_cnt;
        end
        bit_cnt  <= '0;
        byte_cnt <= '0;
        obit     <= '0;
        miso_oe  <= 1'b0;
      end else begin
        if (rise) begin
          in_sh   <= rx_byte[6:0];
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            if (byte_cnt == 3'd0)            opcode <= rx_byte;
            else if (byte_cnt <= ARG_BYTES)  arg    <= {arg[ARG_W-9:0], rx_byte};
            if (byte_cnt != MAX_BYTES)       byte_cnt <= byte_cnt + 3'd1;
          end
        end
        if (fall && byte_cnt != 3'd0 && opcode == OPC_RD_STAT) begin
          miso_oe <= 1'b1;
          obit    <= obit + 3'd1;
          if (obit == 3'd0) begin
            miso   <= stat_byte[7];
            out_sh <= {stat_byte[6:0], 1'b0};
          end else begin
            miso   <= out_sh[7];
            out_sh <= {out_sh[6:0], 1'b0};
          end
        end
      end
    end
  end

  // R2: output stays released until the opcode byte is complete
  a_r2_quiet_opcode: assert property (@(posedge clk) disable iff (rst)
    (byte_cnt == 3'd0) |-> !miso_oe);

  // R10: a command strobe follows a chip-select rise and lasts one clock
  a_r10_strobe_once: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid);

endmodule

// File: rtl/spi_stat_regs.sv
module spi_stat_regs
  import spi_stat_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int SECTORS = 16,
  parameter int ARG_W   = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [7:0]        opcode,
  input  logic [2:0]        frame_n,
  input  logic [ARG_W-1:0]  arg,
  input  logic              prot_n,
  input  logic              job_done,
  output logic [7:0]        stat_byte,
  output logic              job_start,
  output logic [1:0]        job_kind,
  output logic [ADDR_W-1:0] job_addr
);

  localparam int              SECT_W = $clog2(SECTORS);
  localparam logic [SECT_W:0] ALL    = SECTORS;
  localparam logic [SECT_W:0] ONE    = 1;

  logic              lock, armed, busy;
  logic [2:0]        guard;
  logic [SECT_W-1:0] sector;
  logic [SECT_W:0]   n_locked;
  logic              sect_locked, hw_lock;
  logic              unused_bits;

  assign stat_byte   = {lock, 2'b00, guard, armed, busy};
  assign sector      = arg[ADDR_W-1 -: SECT_W];
  assign hw_lock     = lock & ~prot_n;
  assign unused_bits = ^{arg[ARG_W-1:ADDR_W], arg[6:5], arg[1:0]};

  always_comb begin
    if (guard == 3'd0)                 n_locked = '0;
    else if (int'(guard) - 1 >= SECT_W) n_locked = ALL;
    else                               n_locked = ONE << (guard - 3'd1);
  end
  assign sect_locked = {1'b0, sector} >= (ALL - n_locked);

  always_ff @(posedge clk) begin
    if (rst) begin
      lock      <= 1'b0;
      guard     <= '0;
      armed     <= 1'b0;
      busy      <= 1'b0;
      job_start <= 1'b0;
      job_kind  <= JOB_WRSTAT;
      job_addr  <= '0;
    end else begin
      job_start <= 1'b0;
      if (job_done && busy) begin
        busy  <= 1'b0;
        armed <= 1'b0;
      end else if (cmd_valid && !busy) begin
        case (opcode)
          OPC_WR_EN:  if (frame_n == 3'd1) armed <= 1'b1;
          OPC_WR_DIS: if (frame_n == 3'd1) armed <= 1'b0;
          OPC_WR_STAT:
            if (frame_n == 3'd2 && armed && !hw_lock) begin
              lock      <= arg[7];
              guard     <= arg[4:2];
              busy      <= 1'b1;
              job_start <= 1'b1;
              job_kind  <= JOB_WRSTAT;
            end
          OPC_PROG:
            if (frame_n >= 3'd4 && armed && !sect_locked) begin
              busy      <= 1'b1;
              job_start <= 1'b1;
              job_kind  <= JOB_PROG;
              job_addr  <= arg[ADDR_W-1:0];
            end
          OPC_SECT_ERS:
            if (frame_n == 3'd4 && armed && !sect_locked) begin
              busy      <= 1'b1;
              job_start <= 1'b1;
              job_kind  <= JOB_SECT;
              job_addr  <= arg[ADDR_W-1:0];
            end
          OPC_BULK_ERS:
            if (frame_n == 3'd1 && armed && guard == 3'd0) begin
              busy      <= 1'b1;
              job_start <= 1'b1;
              job_kind  <= JOB_BULK;
            end
          default: ;
        endcase
      end
    end
  end

  // R4: no job starts unless writes were armed
  a_r4_needs_armed: assert property (@(posedge clk) disable iff (rst)
    job_start |-> $past(armed));

  // R9: a job starts only from the idle state
  a_r9_idle_before: assert property (@(posedge clk) disable iff (rst)
    job_start |-> !$past(busy));

  // R5: completion clears busy and the arm latch
  a_r5_done_clears: assert property (@(posedge clk) disable iff (rst)
    (job_done && busy) |=> (!busy && !armed));

  // R6: hardware lock freezes the lock and guard bits
  a_r6_hw_frozen: assert property (@(posedge clk) disable iff (rst)
    (lock && !prot_n) |=> ($stable(lock) && $stable(guard)));

  // R7: bulk erase only starts with no guard bits set
  a_r7_bulk_clear: assert property (@(posedge clk) disable iff (rst)
    (job_start && job_kind == JOB_BULK) |-> ($past(guard) == 3'd0));

  // R11: start is a single-clock pulse
  a_r11_one_pulse: assert property (@(posedge clk) disable iff (rst)
    job_start |=> !job_start);

endmodule

// File: rtl/spi_stat_ctrl.sv
module spi_stat_ctrl
  import spi_stat_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int SECTORS     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  input  logic              prot_n,
  input  logic              job_done,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  output logic              job_start,
  output logic [1:0]        job_kind,
  output logic [ADDR_W-1:0] job_addr
);

  localparam int ARG_W = 24;

  logic [3:0]       pins_s;
  logic [7:0]       stat_byte, opcode;
  logic [2:0]       frame_n;
  logic [ARG_W-1:0] arg;
  logic             cmd_valid;

  spi_stat_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0101)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({spi_sck, spi_cs_n, spi_mosi, prot_n}),
    .q   (pins_s)
  );

  spi_stat_frontend #(.ARG_W(ARG_W)) u_front (
    .clk       (clk),
    .rst       (rst),
    .sck       (pins_s[3]),
    .cs_n      (pins_s[2]),
    .mosi      (pins_s[1]),
    .stat_byte (stat_byte),
    .miso      (spi_miso),
    .miso_oe   (spi_miso_oe),
    .cmd_valid (cmd_valid),
    .opcode    (opcode),
    .frame_n   (frame_n),
    .arg       (arg)
  );

  spi_stat_regs #(.ADDR_W(ADDR_W), .SECTORS(SECTORS), .ARG_W(ARG_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .opcode    (opcode),
    .frame_n   (frame_n),
    .arg       (arg),
    .prot_n    (pins_s[0]),
    .job_done  (job_done),
    .stat_byte (stat_byte),
    .job_start (job_start),
    .job_kind  (job_kind),
    .job_addr  (job_addr)
  );

endmodule

// File: tb/spi_stat_ctrl_test.sv
`timescale 1ns/1ps
module spi_stat_ctrl_test;

  localparam int H = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, prot_n = 1'b1, job_done = 1'b0;
  logic miso, miso_oe, job_start;
  logic [1:0]  job_kind;
  logic [19:0] job_addr;

  always #2 clk = ~clk;

  spi_stat_ctrl uut (
    .clk(clk), .rst(rst), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .prot_n(prot_n), .job_done(job_done), .spi_miso(miso), .spi_miso_oe(miso_oe),
    .job_start(job_start), .job_kind(job_kind), .job_addr(job_addr)
  );

  int checks = 0, errors = 0;
  logic [7:0] tx [8];
  logic [7:0] rx [8];
  int  done_after = -1;
  bit  mode3 = 0;
  bit  oe_bad, oe_lost;

  // behavioural reference state
  bit       m_lock, m_armed, m_busy;
  bit [2:0] m_guard;
  bit       exp_start;
  int       exp_kind, exp_addr;

  int starts = 0;
  int last_kind, last_addr;
  always @(negedge clk) if (!rst && job_start) begin
    starts++;
    last_kind = job_kind;
    last_addr = job_addr;
  end

  function automatic int m_stat();
    return {m_lock, 2'b00, m_guard, m_armed, m_busy};
  endfunction

  function automatic bit m_locked(int sec);
    int cnt;
    if (m_guard == 0)      cnt = 0;
    else if (m_guard >= 5) cnt = 16;
    else                   cnt = 1 << (m_guard - 1);
    return sec >= 16 - cnt;
  endfunction

  task automatic chk(int act, int exp, string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic half();
    repeat (H) @(negedge clk);
  endtask

  task automatic pulse_done();
    job_done = 1'b1;
    @(negedge clk);
    job_done = 1'b0;
    if (m_busy) begin m_busy = 0; m_armed = 0; end
  endtask

  task automatic frame(int n, int tail);
    oe_bad = 0; oe_lost = 0;
    @(negedge clk);
    cs_n = 1'b0;
    half();
    for (int i = 0; i < n * 8 + tail; i++) begin
      sck  = 1'b0;
      mosi = tx[i/8][7-(i%8)];
      half();
      rx[i/8][7-(i%8)] = miso;
      if (i < 8 && miso_oe) oe_bad = 1;
      if (i >= 8 && !miso_oe) oe_lost = 1;
      sck = 1'b1;
      half();
      if (i % 8 == 7 && i / 8 == done_after) pulse_done();
    end
    sck = mode3 ? 1'b1 : 1'b0;
    half();
    cs_n = 1'b1;
    repeat (4) half();
  endtask

  task automatic model_cmd(int n, int tail);
    int sec;
    exp_start = 0;
    if (tail != 0 || n == 0 || m_busy) return;
    sec = tx[1][3:0];
    case (tx[0])
      8'h06: if (n == 1) m_armed = 1;
      8'h04: if (n == 1) m_armed = 0;
      8'h01: if (n == 2 && m_armed && !(m_lock && !prot_n)) begin
        m_lock = tx[1][7]; m_guard = tx[1][4:2]; m_busy = 1;
        exp_start = 1; exp_kind = 0;
      end
      8'h02: if (n >= 4 && m_armed && !m_locked(sec)) begin
        m_busy = 1; exp_start = 1; exp_kind = 1;
        exp_addr = {tx[1][3:0], tx[2], tx[3]};
      end
      8'hD8: if (n == 4 && m_armed && !m_locked(sec)) begin
        m_busy = 1; exp_start = 1; exp_kind = 2;
        exp_addr = {tx[1][3:0], tx[2], tx[3]};
      end
      8'hC7: if (n == 1 && m_armed && m_guard == 0) begin
        m_busy = 1; exp_start = 1; exp_kind = 3;
      end
      default: ;
    endcase
  endtask

  task automatic send(int n, int tail, string tag);
    starts = 0;
    frame(n, tail);
    model_cmd(n, tail);
    chk(starts, int'(exp_start), {tag, " start count"});
    if (exp_start) begin
      chk(last_kind, exp_kind, {tag, " job kind"});
      if (exp_kind == 1 || exp_kind == 2) chk(last_addr, exp_addr, {tag, " job address"});
    end
  endtask

  task automatic cmd1(logic [7:0] op, string tag);
    tx[0] = op;
    send(1, 0, tag);
  endtask

  task automatic wrstat(logic [7:0] v, string tag);
    tx[0] = 8'h01; tx[1] = v;
    send(2, 0, tag);
  endtask

  task automatic erase(logic [7:0] a2, logic [7:0] a1, logic [7:0] a0, string tag);
    tx[0] = 8'hD8; tx[1] = a2; tx[2] = a1; tx[3] = a0;
    send(4, 0, tag);
  endtask

  task automatic read_stat(string tag);
    tx[0] = 8'h05; tx[1] = 8'h00; tx[2] = 8'h00;
    frame(3, 0);
    chk(int'(rx[1]), m_stat(), {tag, " status copy 1"});
    chk(int'(rx[2]), m_stat(), {tag, " status copy 2"});
    chk(int'(oe_bad), 0, "R2 miso_oe during opcode");
    chk(int'(oe_lost), 0, "R2 miso_oe while streaming");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int pre;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk(int'(job_start), 0, "R1 job_start after reset");
    read_stat("R1 reset");

    // R4: write without arming
    wrstat(8'h9C, "R4 unarmed status write");
    read_stat("R4 after refused write");

    // R3: arm, disarm, re-arm
    cmd1(8'h06, "R3 arm");
    read_stat("R3 armed");
    cmd1(8'h04, "R3 disarm");
    read_stat("R3 disarmed");
    cmd1(8'h06, "R3 rearm");

    // R10: disarm frame cut three bits into a byte
    tx[0] = 8'h04; tx[1] = 8'hFF;
    send(1, 3, "R10 partial frame");
    read_stat("R10 arm kept");

    // R5: accepted status write
    wrstat(8'h8C, "R5 status write");
    read_stat("R5 busy");
    cmd1(8'h04, "R9 disarm while busy");
    cmd1(8'h06, "R9 arm while busy");
    read_stat("R9 unchanged");

    // R2: job completes between two repeated status bytes
    pre = m_stat();
    tx[0] = 8'h05; tx[1] = 8'h00; tx[2] = 8'h00;
    done_after = 1;
    frame(3, 0);
    done_after = -1;
    chk(int'(rx[1]), pre, "R2 copy before done");
    chk(int'(rx[2]), m_stat(), "R2 refreshed copy after done");

    // R8: guard 3 fences sectors 12..15
    cmd1(8'h06, "R8 arm");
    tx[0] = 8'h02; tx[1] = 8'h0B; tx[2] = 8'h00; tx[3] = 8'h00; tx[4] = 8'hA5;
    send(5, 0, "R8 program sector 11");
    pulse_done();
    cmd1(8'h06, "R8 arm");
    erase(8'h0C, 8'h12, 8'h34, "R8 erase sector 12 fenced");
    read_stat("R8 armed after refusal");
    erase(8'h00, 8'h00, 8'h00, "R8 erase sector 0");
    pulse_done();

    // R7: bulk erase with guard bits set
    cmd1(8'h06, "R7 arm");
    cmd1(8'hC7, "R7 bulk refused");
    read_stat("R7 after refusal");

    // R6: hardware lock
    prot_n = 1'b0;
    wrstat(8'h00, "R6 locked write");
    read_stat("R6 unchanged");
    prot_n = 1'b1;
    wrstat(8'h00, "R6 unlocked write");
    pulse_done();
    read_stat("R6 cleared");

    // R7: bulk erase with guard clear
    cmd1(8'h06, "R7 arm");
    cmd1(8'hC7, "R7 bulk accepted");
    pulse_done();

    // mode 3 from here on
    mode3 = 1;
    @(negedge clk) sck = 1'b1;
    half();
    cmd1(8'h06, "R2 mode3 arm");
    read_stat("R2 mode3 read");
    wrstat(8'h1C, "R8 guard 7");
    pulse_done();
    cmd1(8'h06, "R8 arm");
    erase(8'h00, 8'h00, 8'h00, "R8 guard 7 sector 0 fenced");
    read_stat("R8 guard 7 status");
    cmd1(8'h04, "R3 disarm");
    wrstat(8'h14, "R4 unarmed guard write");
    cmd1(8'h06, "R8 arm");
    wrstat(8'h14, "R8 guard 5");
    pulse_done();
    cmd1(8'h06, "R8 arm");
    erase(8'h00, 8'h00, 8'h00, "R8 guard 5 sector 0 fenced");
    wrstat(8'h04, "R8 guard 1");
    pulse_done();
    cmd1(8'h06, "R8 arm");
    erase(8'h0F, 8'hFF, 8'h00, "R8 guard 1 sector 15 fenced");
    erase(8'h0E, 8'h80, 8'h01, "R8 guard 1 sector 14");
    pulse_done();
    read_stat("R11 final");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule